// File: doc/BRIEF.md
# Integer ALU with condition-flag generation

This block is the arithmetic and logic stage of a 32-bit load/store processor core. It receives an operation code, two operands, the carry bit produced by the barrel shifter, a set-flags bit and the index of the destination register. In the same cycle it returns the result, a destination write-enable and a pipeline flush request. The condition flags N, Z, C and V are held in a register inside the block. That register feeds the carry-in of the carry-using operations and is exposed as an output.

Sixteen operations are supported: six bitwise ones, plain and reverse subtraction, addition with and without carry-in, subtraction with borrow in both operand orders, and four compare/test operations. The compare/test operations update the flags but never write a register. An operation that writes register 15, the program counter, requests a pipeline reload.

If such a write also has the set-flags bit high, the block does not compute new flags. It loads the flag register from a saved status copy and raises a restore request.

Top module: `dp_alu`

## Requirements
- R1: While reset is low the flag register reads 0000. The flag vector bit order is {N, Z, C, V}, with N in bit 3 and V in bit 0.
- R2: The result is combinational.
  - Code 0x0 and code 0x8 give A&B. Code 0x1 and code 0x9 give A^B. Code 0xC gives A|B. Code 0xD gives B. Code 0xE gives A&~B. Code 0xF gives ~B.
  - Code 0x2 and code 0xA give A-B. Code 0x3 gives B-A. Code 0x4 and code 0xB give A+B. Code 0x5 gives A+B+C.
  - Code 0x6 gives A-B-(1-C). Code 0x7 gives B-A-(1-C).
  - C is the registered carry flag.
- R3: The destination write-enable is low for codes 0x8 to 0xB and high for every other code.
- R4: The flush request is high exactly when the write-enable is high and the destination index is 15.
- R5: When the set-flags bit is high, the write-enable is high and the destination index is 15, the restore request is high. At the next clock edge the flag register loads the saved-flags input, and no computed flag value is used.
- R6: The flag register updates at the clock edge in two cases: for codes 0x8 to 0xB regardless of the set-flags bit, and for other codes only when the set-flags bit is high. In all other cases it holds its value.
- R7: For the bitwise codes (0x0, 0x1, 0x8, 0x9, 0xC to 0xF) an update gives N = result bit 31, Z = (result == 0), C = shifter carry, and V unchanged.
- R8: For codes 0x4, 0x5 and 0xB an update gives C = unsigned carry out of the 32-bit sum. V = bit 31 of (A^res)&(B^res).
- R9: For codes 0x2 and 0xA an update gives C = (B <= A) unsigned and V = bit 31 of (A^res)&(~B^res). Code 0x3 uses the same rules with A and B exchanged. N and Z follow R7's definition for all three.
- R10: For code 0x6 an update gives C = ((B + 1 - C_old) <= A), evaluated without wrap, and V takes the code 0x2 form. Code 0x7 mirrors this with A and B exchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the flag register |
| op_code | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, already shifted |
| shift_carry | input | 1 | Carry out of the barrel shifter |
| set_flags | input | 1 | Request a flag update |
| dest_idx | input | 4 | Destination register index |
| saved_flags | input | 4 | Saved status flags {N,Z,C,V} |
| result | output | 32 | Operation result |
| dest_we | output | 1 | Destination register write-enable |
| flush_req | output | 1 | Pipeline reload request |
| restore_req | output | 1 | Restore status from saved copy |
| flags | output | 4 | Registered flags {N,Z,C,V} |

## Verification
The bench seeds the carry flag through a restore before each vector. This exposes two kinds of carry-in bug. A design that took carry-in from the shifter instead of the flag register gives wrong add-with-carry and borrow results. A design that let the 33-bit borrow subtrahend wrap reports carry set when subtracting all-ones with a clear carry.

Signed-overflow edges are driven in every operand order: the most negative value minus one, and its reverse. A swapped V term in the reverse codes would show up there.

A flag-setting write to register 15 whose computed flags differ from the saved word catches a design that merges the two sources. A compare aimed at register 15 with flags requested catches a design that flushes or restores on a non-writing code. A bitwise operation checks that the pre-seeded V survives.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
        OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
        OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
        OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
    } alu_op_e;

    typedef enum logic [2:0] {
        LF_AND, LF_XOR, LF_OR, LF_PASS, LF_CLEAR, LF_NOT
    } logic_fn_e;

    typedef enum logic [1:0] {
        CIN_ZERO, CIN_ONE, CIN_FLAG
    } cin_sel_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic      is_logic;
        logic      is_test;
        logic      swap;
        logic      invert;
        cin_sel_e  cin;
        logic_fn_e lfn;
    } alu_ctl_t;

endpackage

// File: rtl/dp_alu_decode.sv
module dp_alu_decode
    import dp_alu_pkg::*;
(
    input  logic [3:0] op_code,
    output alu_ctl_t   ctl
);

    always_comb begin
        ctl          = '0;
        ctl.cin      = CIN_ZERO;
        ctl.lfn      = LF_AND;
        ctl.is_test  = (op_code[3:2] == 2'b10);
        case (alu_op_e'(op_code))
            OP_AND, OP_TST: begin ctl.is_logic = 1'b1; ctl.lfn = LF_AND;   end
            OP_EOR, OP_TEQ: begin ctl.is_logic = 1'b1; ctl.lfn = LF_XOR;   end
            OP_ORR:         begin ctl.is_logic = 1'b1; ctl.lfn = LF_OR;    end
            OP_MOV:         begin ctl.is_logic = 1'b1; ctl.lfn = LF_PASS;  end
            OP_BIC:         begin ctl.is_logic = 1'b1; ctl.lfn = LF_CLEAR; end
            OP_MVN:         begin ctl.is_logic = 1'b1; ctl.lfn = LF_NOT;   end
            OP_SUB, OP_CMP: begin ctl.invert = 1'b1; ctl.cin = CIN_ONE;  end
            OP_RSB:         begin ctl.invert = 1'b1; ctl.swap = 1'b1; ctl.cin = CIN_ONE; end
            OP_ADD, OP_CMN: begin ctl.cin = CIN_ZERO; end
            OP_ADC:         begin ctl.cin = CIN_FLAG; end
            OP_SBC:         begin ctl.invert = 1'b1; ctl.cin = CIN_FLAG; end
            OP_RSC:         begin ctl.invert = 1'b1; ctl.swap = 1'b1; ctl.cin = CIN_FLAG; end
            default:        begin ctl.is_logic = 1'b1; end
        endcase
    end

endmodule

// File: rtl/dp_alu_datapath.sv
module dp_alu_datapath
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_ctl_t     ctl,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         old_c,
    output logic [W-1:0] res,
    output logic         carry,
    output logic         ovf
);

    localparam int SW = W + 1;

    logic [W-1:0]  x_op;
    logic [W-1:0]  y_op;
    logic          cin_bit;
    logic [SW-1:0] sum_w;
    logic [W-1:0]  arith_res;
    logic [W-1:0]  logic_res;

    always_comb begin
        x_op = ctl.swap ? b : a;
        y_op = ctl.swap ? a : b;
        if (ctl.invert) y_op = ~y_op;
        case (ctl.cin)
            CIN_ZERO: cin_bit = 1'b0;
            CIN_ONE:  cin_bit = 1'b1;
            default:  cin_bit = old_c;
        endcase
        sum_w     = {1'b0, x_op} + {1'b0, y_op} + {{W{1'b0}}, cin_bit};
        arith_res = sum_w[W-1:0];
        carry     = sum_w[W];
        ovf       = (x_op[W-1] ^ arith_res[W-1]) & (y_op[W-1] ^ arith_res[W-1]);
        case (ctl.lfn)
            LF_AND:   logic_res = a & b;
            LF_XOR:   logic_res = a ^ b;
            LF_OR:    logic_res = a | b;
            LF_PASS:  logic_res = b;
            LF_CLEAR: logic_res = a & ~b;
            default:  logic_res = ~b;
        endcase
        res = ctl.is_logic ? logic_res : arith_res;
    end

endmodule

// File: rtl/dp_alu_flagreg.sv
module dp_alu_flagreg
    import dp_alu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   upd,
    input  logic   restore,
    input  flags_t fresh,
    input  flags_t saved,
    output flags_t flags_o
);

    typedef struct packed {
        flags_t flags;
    } st_t;

    st_t st_d;
    st_t st_q;

    always_comb begin
        st_d = st_q;
        if (restore)  st_d.flags = saved;
        else if (upd) st_d.flags = fresh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    // R5
    restore_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (flags_o == $past(saved)));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !restore) |=> $stable(flags_o));

endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int W      = 32,
    parameter int IDX_W  = 4,
    parameter int PC_IDX = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_code,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    input  logic             shift_carry,
    input  logic             set_flags,
    input  logic [IDX_W-1:0] dest_idx,
    input  logic [3:0]       saved_flags,
    output logic [W-1:0]     result,
    output logic             dest_we,
    output logic             flush_req,
    output logic             restore_req,
    output logic [3:0]       flags
);

    localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);

    typedef struct packed {
        logic   we;
        logic   flush;
        logic   restore;
        logic   upd;
        flags_t fresh;
    } out_t;

    alu_ctl_t     ctl;
    logic [W-1:0] dp_res;
    logic         dp_carry;
    logic         dp_ovf;
    flags_t       cur_flags;
    out_t         out_d;

    dp_alu_decode u_decode (
        .op_code (op_code),
        .ctl     (ctl)
    );

    dp_alu_datapath #(.W(W)) u_datapath (
        .ctl   (ctl),
        .a     (opnd_a),
        .b     (opnd_b),
        .old_c (cur_flags.c),
        .res   (dp_res),
        .carry (dp_carry),
        .ovf   (dp_ovf)
    );

    always_comb begin
        out_d         = '0;
        out_d.we      = !ctl.is_test;
        out_d.flush   = out_d.we && (dest_idx == PC_SEL);
        out_d.restore = out_d.flush && set_flags;
        out_d.upd     = ctl.is_test || (set_flags && !out_d.restore);
        out_d.fresh.n = dp_res[W-1];
        out_d.fresh.z = (dp_res == '0);
        out_d.fresh.c = ctl.is_logic ? shift_carry : dp_carry;
        out_d.fresh.v = ctl.is_logic ? cur_flags.v : dp_ovf;
    end

    dp_alu_flagreg u_flagreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (out_d.upd),
        .restore (out_d.restore),
        .fresh   (out_d.fresh),
        .saved   (flags_t'(saved_flags)),
        .flags_o (cur_flags)
    );

    assign result      = dp_res;
    assign dest_we     = out_d.we;
    assign flush_req   = out_d.flush;
    assign restore_req = out_d.restore;
    assign flags       = cur_flags;

    // R3
    test_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code[3:2] == 2'b10) |-> !dest_we);

    // R4
    flush_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> (dest_we && dest_idx == PC_SEL));

    // R6
    test_updates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code[3:2] == 2'b10) |=> (flags[3] == $past(result[W-1])));

    // R7
    logic_keeps_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.is_logic && !restore_req) |=> $stable(flags[0]));

endmodule

// File: tb/dp_alu_tb_top.sv
module dp_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_code = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        shift_carry = 1'b0;
    logic        set_flags = 1'b0;
    logic [3:0]  dest_idx = '0;
    logic [3:0]  saved_flags = '0;
    logic [31:0] result;
    logic        dest_we;
    logic        flush_req;
    logic        restore_req;
    logic [3:0]  flags;

    always #2 clk = ~clk;

    dp_alu dut_i (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .shift_carry(shift_carry), .set_flags(set_flags),
        .dest_idx(dest_idx), .saved_flags(saved_flags), .result(result),
        .dest_we(dest_we), .flush_req(flush_req), .restore_req(restore_req),
        .flags(flags)
    );

    int n_checks = 0;
    int n_bad = 0;

    // {op, a, b, shifter carry, seeded carry flag}
    localparam int NV = 24;
    localparam logic [69:0] VECS [0:NV-1] = '{
        {4'h0, 32'hFFFF0000, 32'h0F0F0F0F, 1'b1, 1'b0},
        {4'h1, 32'hAAAAAAAA, 32'hAAAAAAAA, 1'b0, 1'b1},
        {4'hC, 32'h80000000, 32'h00000001, 1'b1, 1'b0},
        {4'hD, 32'h12345678, 32'h00000000, 1'b0, 1'b1},
        {4'hE, 32'hFFFFFFFF, 32'h0000FFFF, 1'b1, 1'b1},
        {4'hF, 32'h00000000, 32'h00000000, 1'b0, 1'b0},
        {4'h2, 32'h00000005, 32'h00000005, 1'b0, 1'b0},
        {4'h2, 32'h00000003, 32'h00000005, 1'b1, 1'b1},
        {4'h2, 32'h80000000, 32'h00000001, 1'b0, 1'b0},
        {4'h3, 32'h00000005, 32'h00000003, 1'b0, 1'b1},
        {4'h3, 32'h00000001, 32'h80000000, 1'b1, 1'b0},
        {4'h4, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b0},
        {4'h4, 32'h7FFFFFFF, 32'h00000001, 1'b1, 1'b1},
        {4'h5, 32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b1},
        {4'h5, 32'h00000001, 32'h00000002, 1'b1, 1'b0},
        {4'h6, 32'h00000005, 32'h00000005, 1'b1, 1'b0},
        {4'h6, 32'h00000005, 32'h00000005, 1'b0, 1'b1},
        {4'h6, 32'h00000000, 32'hFFFFFFFF, 1'b0, 1'b0},
        {4'h7, 32'h00000005, 32'h00000005, 1'b1, 1'b0},
        {4'h7, 32'h00000000, 32'h7FFFFFFF, 1'b0, 1'b1},
        {4'h8, 32'h000000F0, 32'h0000000F, 1'b1, 1'b0},
        {4'h9, 32'h80000001, 32'h00000001, 1'b0, 1'b1},
        {4'hA, 32'h00000001, 32'h00000002, 1'b1, 1'b1},
        {4'hB, 32'h80000000, 32'h80000000, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string flag_req(input logic [3:0] op);
        case (op)
            4'h4, 4'h5, 4'hB: return "R8";
            4'h2, 4'h3, 4'hA: return "R9";
            4'h6, 4'h7:       return "R10";
            default:          return "R7";
        endcase
    endfunction

    // returns {result, N, Z, C, V}
    function automatic logic [35:0] model(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic shc,
                                          input logic [3:0] fl);
        logic [63:0] wa, wb, wc, wide;
        logic [31:0] r, t;
        logic c, v;
        wa = {32'd0, a}; wb = {32'd0, b}; wc = {63'd0, fl[1]};
        c = fl[1]; v = fl[0]; r = '0;
        case (op)
            4'h0, 4'h8: begin r = a & b;  c = shc; end
            4'h1, 4'h9: begin r = a ^ b;  c = shc; end
            4'hC:       begin r = a | b;  c = shc; end
            4'hD:       begin r = b;      c = shc; end
            4'hE:       begin r = a & ~b; c = shc; end
            4'hF:       begin r = ~b;     c = shc; end
            4'h2, 4'hA: begin r = a - b; c = (wb <= wa);
                        t = (a ^ r) & (~b ^ r); v = t[31]; end
            4'h3:       begin r = b - a; c = (wa <= wb);
                        t = (b ^ r) & (~a ^ r); v = t[31]; end
            4'h4, 4'hB, 4'h5: begin
                        wide = wa + wb + ((op == 4'h5) ? wc : 64'd0);
                        r = wide[31:0]; c = wide[32];
                        t = (a ^ r) & (b ^ r); v = t[31]; end
            4'h6:       begin r = a - b - {31'd0, ~fl[1]};
                        c = ((wb - wc + 64'd1) <= wa);
                        t = (a ^ r) & (~b ^ r); v = t[31]; end
            default:    begin r = b - a - {31'd0, ~fl[1]};
                        c = ((wa - wc + 64'd1) <= wb);
                        t = (b ^ r) & (~a ^ r); v = t[31]; end
        endcase
        return {r, r[31], (r == 32'd0), c, v};
    endfunction

    task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic shc, input logic sf, input logic [3:0] di,
                         input logic [3:0] sv);
        @(negedge clk);
        op_code = op; opnd_a = a; opnd_b = b; shift_carry = shc;
        set_flags = sf; dest_idx = di; saved_flags = sv;
        #1;
    endtask

    task automatic preload(input logic [3:0] val);
        drive(4'hD, 32'd0, 32'd0, 1'b0, 1'b1, 4'd15, val);
        check("R5 restore request", {31'd0, restore_req}, 32'd1);
        @(posedge clk); #1;
        check("R5 flags loaded from saved copy", {28'd0, flags}, {28'd0, val});
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog R1: actual hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
        $finish;
    end

    initial begin
        logic [35:0] m;
        logic [3:0]  seed;
        repeat (3) @(posedge clk);
        #1;
        check("R1 flags in reset", {28'd0, flags}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [69:0] v;
            logic [3:0]  di;
            logic        we_exp;
            v    = VECS[i];
            seed = {1'b0, 1'b1, v[0], 1'b1};
            preload(seed);
            di = 4'(i % 15);
            we_exp = (v[69:66] < 4'h8) || (v[69:66] > 4'hB);
            m = model(v[69:66], v[65:34], v[33:2], v[1], seed);
            drive(v[69:66], v[65:34], v[33:2], v[1], 1'b1, di, 4'd0);
            check("R2 result", result, m[35:4]);
            check("R3 write enable", {31'd0, dest_we}, {31'd0, we_exp});
            check("R4 no flush below 15", {31'd0, flush_req}, 32'd0);
            @(posedge clk); #1;
            check(flag_req(v[69:66]), {28'd0, flags}, {28'd0, m[3:0]});
        end

        // R6: no set-flags on a writing code leaves flags alone
        preload(4'b0000);
        drive(4'h4, 32'h7FFFFFFF, 32'h1, 1'b1, 1'b0, 4'd2, 4'd0);
        @(posedge clk); #1;
        check("R6 hold without set-flags", {28'd0, flags}, 32'd0);

        // R6: compare updates even with set-flags low
        m = model(4'hA, 32'd1, 32'd2, 1'b0, 4'b0000);
        drive(4'hA, 32'd1, 32'd2, 1'b0, 1'b0, 4'd3, 4'd0);
        @(posedge clk); #1;
        check("R6 compare always updates", {28'd0, flags}, {28'd0, m[3:0]});

        // R4: write to 15 without set-flags flushes, no restore
        preload(4'b0011);
        drive(4'h4, 32'd1, 32'd2, 1'b0, 1'b0, 4'd15, 4'b1100);
        check("R4 flush on pc write", {31'd0, flush_req}, 32'd1);
        check("R4 write enable on pc write", {31'd0, dest_we}, 32'd1);
        check("R5 no restore without set-flags", {31'd0, restore_req}, 32'd0);
        @(posedge clk); #1;
        check("R6 flags held on pc write", {28'd0, flags}, 32'h3);

        // R5: flag-setting pc write takes saved word, not computed flags
        preload(4'b0101);
        drive(4'h2, 32'd0, 32'd0, 1'b0, 1'b1, 4'd15, 4'b1010);
        check("R5 restore on flag-setting pc write", {31'd0, restore_req}, 32'd1);
        check("R4 flush with restore", {31'd0, flush_req}, 32'd1);
        @(posedge clk); #1;
        check("R5 saved word replaces computed flags", {28'd0, flags}, 32'hA);

        // R4/R5: compare aimed at 15 neither flushes nor restores
        m = model(4'hA, 32'd2, 32'd2, 1'b0, 4'b1010);
        drive(4'hA, 32'd2, 32'd2, 1'b0, 1'b1, 4'd15, 4'b1111);
        check("R4 no flush on compare to 15", {31'd0, flush_req}, 32'd0);
        check("R5 no restore on compare to 15", {31'd0, restore_req}, 32'd0);
        @(posedge clk); #1;
        check("R9 compare to 15 flags", {28'd0, flags}, {28'd0, m[3:0]});

        // R1: reset mid-run clears flags
        preload(4'b1111);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 flags cleared by reset", {28'd0, flags}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
        $finish;
    end

endmodule